// File: doc/BRIEF.md
# Cold Reset and Strap Sequencer

This block runs the power-on handshake for one processor socket. It is clocked by the bus reference clock. It drives an active-low processor reset, a power-good output, a 5-bit active-low bus-to-core ratio strap bus and a group of other configuration straps. A single start pulse in the idle state captures the requested ratio code and the configuration value. The block then steps through a fixed order:

1. Arm the ratio straps while reset is held.
2. Raise power-good.
3. Wait one millisecond's worth of clocks, with the configuration straps driven during the last few clocks of that wait.
4. Release reset.
5. Keep every strap steady for three more clocks.
6. Drop the strap output enables.

A ratio code outside the five supported values is never driven. The block stays in reset and raises a sticky error flag instead. The cycles-per-millisecond count is a parameter so that the block fits any reference clock rate.

Top module: `cold_rst_seq`

## Requirements
- R1: After rst_n is low, the block is idle: cpu_rst_n=0, pwr_ok=0, ratio_oe=0, cfg_oe=0, ratio_pin_n=5'b11111, cfg_pin=0, done=0 and err=0.
- R2: The supported ratio codes are 10110, 10101, 10010, 10001 and 10000, where bit 4 is the leftmost bit and a 1 means the pin is driven low. A start in idle with a supported code gives, one clock later, ratio_oe=1 and ratio_pin_n equal to the inverted code, while cpu_rst_n=0 and pwr_ok=0.
- R3: pwr_ok rises one clock after the ratio straps are armed and then stays high. cpu_rst_n rises exactly MS_CYC clocks after pwr_ok rises.
- R4: cfg_oe rises, with cfg_pin equal to the cfg_req value captured at start, exactly SETUP_CLKS clocks before cpu_rst_n rises. Until then cfg_pin reads 0.
- R5: Both strap groups keep their captured values for HOLD_CLKS (3) clocks after cpu_rst_n rises. Then ratio_oe and cfg_oe drop, the pins return to their released values and done goes high and stays high.
- R6: A start in idle with any other ratio code sets err one clock later and keeps it set until rst_n. cpu_rst_n and pwr_ok stay low, and neither strap group is enabled.
- R7: start, ratio_req and cfg_req are ignored outside the idle state, whether during the sequence, after done, or after err.
- R8: While ratio_oe is high, ratio_pin_n always carries a supported code and does not change. ratio_oe is high whenever cpu_rst_n is low and pwr_ok is high.
- R9: cpu_rst_n is never high while pwr_ok is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock |
| rst_n | input | 1 | Active-low reset of the sequencer itself |
| start | input | 1 | Request to begin the cold-reset sequence (taken in idle only) |
| ratio_req | input | 5 | Requested ratio code, 1 meaning pin driven low |
| cfg_req | input | CFG_W | Value for the other configuration straps |
| cpu_rst_n | output | 1 | Active-low processor reset |
| pwr_ok | output | 1 | Power-good indication to the processor |
| ratio_pin_n | output | 5 | Active-low ratio strap levels, all ones when released |
| ratio_oe | output | 1 | Ratio strap driver enable |
| cfg_pin | output | CFG_W | Other configuration strap levels, zero when released |
| cfg_oe | output | 1 | Configuration strap driver enable |
| done | output | 1 | Straps released, sequence complete |
| err | output | 1 | Sticky flag for a refused reserved ratio code |

## Verification
The checker watches a set of properties on every cycle:
- reset is never released without power-good;
- the ratio pins always show a supported and steady code while enabled;
- at least MS_CYC clocks of power-good and SETUP_CLKS clocks of configuration setup pass before reset is released;
- the straps stay enabled for two to three clocks after release;
- done and err behave as final states.

The exact cycle on which each edge lands can only be shown by the bench's sweeps. The same holds for the captured values on the pins, the refusal of each of the 27 reserved codes, and starts being ignored mid-sequence, after done and after an error.

// File: rtl/cold_rst_seq.sv
module cold_rst_seq #(
  parameter int MS_CYC     = 100000,
  parameter int SETUP_CLKS = 4,
  parameter int HOLD_CLKS  = 3,
  parameter int CFG_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [4:0]       ratio_req,
  input  logic [CFG_W-1:0] cfg_req,
  output logic             cpu_rst_n,
  output logic             pwr_ok,
  output logic [4:0]       ratio_pin_n,
  output logic             ratio_oe,
  output logic [CFG_W-1:0] cfg_pin,
  output logic             cfg_oe,
  output logic             done,
  output logic             err
);
  localparam int CW = $clog2(MS_CYC + 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(MS_CYC - 1);
  localparam logic [CW-1:0] CFG_FROM  = CW'(MS_CYC - SETUP_CLKS);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CLKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_PWR, S_HOLD, S_DONE, S_ERR} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [4:0]       code_q;
  logic [CFG_W-1:0] cfg_q;
  logic             req_ok;

  assign req_ok = (ratio_req == 5'b10110) || (ratio_req == 5'b10101) ||
                  (ratio_req == 5'b10010) || (ratio_req == 5'b10001) ||
                  (ratio_req == 5'b10000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      code_q <= '0;
      cfg_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          if (req_ok) begin
            st     <= S_ARM;
            code_q <= ratio_req;
            cfg_q  <= cfg_req;
          end else begin
            st <= S_ERR;
          end
        end
        S_ARM: begin
          st  <= S_PWR;
          cnt <= '0;
        end
        S_PWR: begin
          if (cnt == WAIT_LAST) begin
            st  <= S_HOLD;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (cnt == HOLD_LAST) st <= S_DONE;
          else                  cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign pwr_ok    = (st == S_PWR) || (st == S_HOLD) || (st == S_DONE);
  assign cpu_rst_n = (st == S_HOLD) || (st == S_DONE);
  assign ratio_oe  = (st == S_ARM) || (st == S_PWR) || (st == S_HOLD);
  assign cfg_oe    = ((st == S_PWR) && (cnt >= CFG_FROM)) || (st == S_HOLD);
  assign done      = (st == S_DONE);
  assign err       = (st == S_ERR);

  assign ratio_pin_n = ratio_oe ? ~code_q : 5'b11111;
  assign cfg_pin     = cfg_oe ? cfg_q : '0;

  initial begin
    if (SETUP_CLKS < 1 || SETUP_CLKS > MS_CYC) $error("SETUP_CLKS out of range");
    if (HOLD_CLKS < 2 || HOLD_CLKS > 3) $error("HOLD_CLKS outside 2..3");
  end
endmodule

// File: rtl/cold_rst_seq_chk.sv
module cold_rst_seq_chk #(
  parameter int MS_CYC     = 100000,
  parameter int SETUP_CLKS = 4,
  parameter int CFG_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_rst_n,
  input logic             pwr_ok,
  input logic [4:0]       ratio_pin_n,
  input logic             ratio_oe,
  input logic [CFG_W-1:0] cfg_pin,
  input logic             cfg_oe,
  input logic             done,
  input logic             err
);
  localparam int CW = $clog2(MS_CYC + 1);

  logic [CW-1:0] pg_cnt;
  logic [CW-1:0] su_cnt;
  logic [2:0]    rel_cnt;
  logic [4:0]    code;

  assign code = ~ratio_pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_cnt  <= '0;
      su_cnt  <= '0;
      rel_cnt <= '0;
    end else begin
      if (!pwr_ok)                      pg_cnt <= '0;
      else if (pg_cnt < CW'(MS_CYC))    pg_cnt <= pg_cnt + 1'b1;
      if (!cfg_oe)                      su_cnt <= '0;
      else if (su_cnt < CW'(SETUP_CLKS)) su_cnt <= su_cnt + 1'b1;
      if (!cpu_rst_n)                   rel_cnt <= '0;
      else if (rel_cnt != 3'd7)         rel_cnt <= rel_cnt + 1'b1;
    end
  end

  // R9
  no_run_without_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !cpu_rst_n);

  // R8
  legal_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_oe |-> (code == 5'b10110 || code == 5'b10101 || code == 5'b10010 ||
                  code == 5'b10001 || code == 5'b10000));

  // R8
  ratio_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_oe && $past(ratio_oe)) |-> $stable(ratio_pin_n));

  // R8
  ratio_during_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !cpu_rst_n) |-> ratio_oe);

  // R3
  min_pg_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> (pg_cnt >= CW'(MS_CYC)));

  // R4
  cfg_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> (cfg_oe && su_cnt >= CW'(SETUP_CLKS)));

  // R5
  hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ratio_oe) && cpu_rst_n) |-> (rel_cnt >= 3'd2 && rel_cnt <= 3'd3));

  // R5
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ratio_oe && !cfg_oe && cpu_rst_n && cfg_pin == '0));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !pwr_ok && !ratio_oe));
endmodule

bind cold_rst_seq cold_rst_seq_chk #(.MS_CYC(MS_CYC), .SETUP_CLKS(SETUP_CLKS), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rst_n(cpu_rst_n), .pwr_ok(pwr_ok),
  .ratio_pin_n(ratio_pin_n), .ratio_oe(ratio_oe), .cfg_pin(cfg_pin),
  .cfg_oe(cfg_oe), .done(done), .err(err));

// File: tb/tb_cold_rst_seq.sv
module tb_cold_rst_seq;
  localparam int MS  = 12;
  localparam int SU  = 4;
  localparam int HD  = 3;
  localparam int CW  = 6;
  localparam int TOT = MS + HD + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] ratio_req = '0;
  logic [CW-1:0] cfg_req = '0;
  logic cpu_rst_n, pwr_ok, ratio_oe, cfg_oe, done, err;
  logic [4:0] ratio_pin_n;
  logic [CW-1:0] cfg_pin;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cold_rst_seq #(.MS_CYC(MS), .SETUP_CLKS(SU), .HOLD_CLKS(HD), .CFG_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ratio_req(ratio_req), .cfg_req(cfg_req),
    .cpu_rst_n(cpu_rst_n), .pwr_ok(pwr_ok), .ratio_pin_n(ratio_pin_n), .ratio_oe(ratio_oe),
    .cfg_pin(cfg_pin), .cfg_oe(cfg_oe), .done(done), .err(err));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit supported(input logic [4:0] c);
    return c == 5'd22 || c == 5'd21 || c == 5'd18 || c == 5'd17 || c == 5'd16;
  endfunction

  task automatic check_all(input string tag, input bit r, input bit p, input bit ro,
                           input bit co, input bit d, input bit e,
                           input logic [4:0] pins, input logic [CW-1:0] cfg);
    chk({tag, " cpu_rst_n"}, int'(cpu_rst_n), int'(r));
    chk({tag, " pwr_ok"}, int'(pwr_ok), int'(p));
    chk({tag, " ratio_oe"}, int'(ratio_oe), int'(ro));
    chk({tag, " cfg_oe"}, int'(cfg_oe), int'(co));
    chk({tag, " done"}, int'(done), int'(d));
    chk({tag, " err"}, int'(err), int'(e));
    chk({tag, " ratio_pin_n"}, int'(ratio_pin_n), int'(pins));
    chk({tag, " cfg_pin"}, int'(cfg_pin), int'(cfg));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R1 idle", 0, 0, 0, 0, 0, 0, 5'b11111, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 idle after release", 0, 0, 0, 0, 0, 0, 5'b11111, '0);
  endtask

  task automatic run(input logic [4:0] code, input logic [CW-1:0] cfg);
    logic [4:0] other;
    other = supported(code ^ 5'b00011) ? (code ^ 5'b00011) : 5'b10000;
    do_reset();
    start = 1'b1; ratio_req = code; cfg_req = cfg;
    @(negedge clk);
    start = 1'b0; ratio_req = ~code; cfg_req = ~cfg;
    if (!supported(code)) begin
      for (int c = 1; c <= 6; c++) begin
        check_all("R6 reserved code refused", 0, 0, 0, 0, 0, 1, 5'b11111, '0);
        if (c == 2) begin start = 1'b1; ratio_req = 5'b10110; end
        if (c == 3) start = 1'b0;
        @(negedge clk);
      end
      return;
    end
    for (int c = 1; c <= TOT; c++) begin
      bit r, p, ro, co, d;
      string tag;
      r = 0; p = 0; ro = 0; co = 0; d = 0;
      if (c == 1) begin ro = 1; tag = "R2 arm"; end
      else if (c <= MS + 1) begin
        p = 1; ro = 1; co = (c - 2 >= MS - SU);
        tag = co ? "R4 cfg setup" : "R3 pg wait";
      end else if (c <= MS + 1 + HD) begin
        r = 1; p = 1; ro = 1; co = 1; tag = "R5 hold";
      end else begin
        r = 1; p = 1; d = 1; tag = "R7 done ignores start";
      end
      check_all(tag, r, p, ro, co, d, 0, ro ? ~code : 5'b11111, co ? cfg : '0);
      if (c == 3 || c == MS + 3 || c == TOT - 2) begin
        start = 1'b1; ratio_req = other; cfg_req = cfg + 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    fork
      begin
        for (int k = 0; k < 32; k++) run(5'(k), CW'(k * 7 + 3));
        run(5'b10110, '1);
        run(5'b10000, '0);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule